// File: doc/BRIEF.md
# EEPROM Page Write Engine

This block sits between the byte-level slave front end of a two-wire serial EEPROM and its byte-wide storage array. The front end pulses a start strobe with the 10-bit target address once the word address has been received. It then presents each incoming data byte with a valid strobe and pulses a stop strobe when a valid stop condition ends the write. The engine gathers up to one 16-byte page of data in a local buffer. Each data byte is answered with an accept or reject flag, which the front end turns into an acknowledge or a missing acknowledge.

On stop the engine enters a self-timed programming interval of a fixed number of clock cycles. It holds `busy_o` high for the whole interval. The front end uses `busy_o` to withhold its address acknowledge, which gives acknowledge polling. During the interval the engine writes the buffered bytes to the array, one slot per cycle. Only the slots that actually received data are written. The page is one of 64 pages: the top 2 address bits select a 256-byte block and the next 4 bits select a page inside it. The low 4 bits are an offset that wraps inside the page. When write protection is on, the upper half of the array rejects data, while the start and stop strobes are still taken.

Top module: `pw_engine`

## Requirements
- R1: After reset `busy_o`, `ack_vld_o`, `ack_o` and `mem_we_o` are all 0.
- R2: A start strobe taken while idle opens a sequence at `addr_i`. It discards any data gathered before it. The first accepted byte is committed to `addr_i`, and each further byte goes to the next offset, where the offset is bits 3:0.
- R3: The offset wraps from 15 to 0 without changing bits 9:4. A byte written to an offset already filled in the same sequence replaces the earlier byte.
- R4: Each data byte received in an open sequence gives `ack_vld_o`=1 in the following cycle, with `ack_o`=1 when the byte is accepted. When `ack_vld_o`=0, `ack_o` is 0.
- R5: With `wp_i`=1 and address bit 9 of the open sequence set, every data byte gives `ack_vld_o`=1 with `ack_o`=0. The offset does not advance and the array stays unchanged.
- R6: With `wp_i`=0, addresses 0x200 to 0x3FF are written like any other.
- R7: A stop strobe that closes a sequence with at least one accepted byte raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `PROG_CYCLES` cycles.
- R8: Only the page slots that accepted a byte are written. Every other array byte keeps its contents.
- R9: While `busy_o` is high, start, data and stop strobes are ignored. They produce no acknowledge and leave no open sequence behind.
- R10: A stop strobe with no accepted byte, or with no open sequence, does not raise `busy_o`.
- R11: `mem_we_o` is high only while `busy_o` is high. All commits of one interval stay inside one page.
- R12: A data strobe with no open sequence is ignored and gives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | Opens a write sequence at addr_i |
| addr_i | input | ADDR_W | Start address of the sequence |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop condition closes the sequence |
| wp_i | input | 1 | Write protect for the upper half |
| busy_o | output | 1 | Programming interval in progress |
| ack_vld_o | output | 1 | Response to the previous data byte is valid |
| ack_o | output | 1 | 1 = byte accepted, 0 = rejected |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
A wrong offset or a wrong page register shows up as a wrong array byte. It cannot be seen on `busy_o` or the acknowledge. It appears only once the interval after the stop strobe ends, as a memory difference at the address the byte was supposed to reach. A wrong write-slot mark shows in the same way, either as a byte that was clobbered or as one that never landed. A wrong sequence-open state or a wrong timer state shows within one cycle, as a missing or extra acknowledge or a `busy_o` edge on the wrong cycle. The bench therefore compares the acknowledge and busy outputs on every clock, and compares the whole array at the end of every interval.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE    = 2'd0,
    PW_COLLECT = 2'd1,
    PW_PROG    = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  localparam int SLOTS = 1 << PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_mark_o,
  output logic              any_o
);
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  mark_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[s] <= '0;
        mark_q[s] <= 1'b0;
      end else if (clr_i) begin
        mark_q[s] <= 1'b0;
      end else if (wr_i && wr_idx_i == PAGE_W'(s)) begin
        slot_q[s] <= wr_data_i;
        mark_q[s] <= 1'b1;
      end
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_mark_o = mark_q[rd_idx_i];
  assign any_o     = |mark_q;
endmodule

// File: rtl/pw_prog_timer.sv
module pw_prog_timer #(
  parameter int PROG_CYCLES = 2000000,
  parameter int PAGE_W      = 4,
  localparam int SLOTS = 1 << PAGE_W,
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              idx_vld_o,
  output logic [PAGE_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && (cnt_q == CNT_W'(PROG_CYCLES - 1));
  // commit one page slot per cycle during the first SLOTS cycles
  assign idx_vld_o = busy_q && (32'(cnt_q) < SLOTS);
  assign idx_o     = cnt_q[PAGE_W-1:0];
endmodule

// File: rtl/pw_engine.sv
module pw_engine #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 2000000,
  localparam int PG_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              ack_vld_o,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  import pw_pkg::*;

  pw_state_e         state_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              ack_vld_q, ack_q;

  logic              buf_any, buf_mark, buf_wr, buf_clr;
  logic [DATA_W-1:0] buf_data;
  logic              tmr_busy, tmr_done, tmr_idx_vld, tmr_start;
  logic [PAGE_W-1:0] tmr_idx;

  logic open_ok, protect, take_start, take_stop, take_byte;

  assign open_ok    = (state_q != PW_PROG);
  assign protect    = wp_i && page_q[PG_W-1];
  assign take_start = open_ok && wr_start_i;
  assign take_stop  = open_ok && !wr_start_i && stop_i;
  assign take_byte  = (state_q == PW_COLLECT) && !wr_start_i && !stop_i && byte_vld_i;

  assign buf_clr    = take_start;
  assign buf_wr     = take_byte && !protect;
  assign tmr_start  = take_stop && (state_q == PW_COLLECT) && buf_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PW_IDLE;
      page_q    <= '0;
      off_q     <= '0;
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_vld_q <= take_byte;
      ack_q     <= take_byte && !protect;
      if (take_start) begin
        state_q <= PW_COLLECT;
        page_q  <= addr_i[ADDR_W-1:PAGE_W];
        off_q   <= addr_i[PAGE_W-1:0];
      end else if (take_stop) begin
        state_q <= tmr_start ? PW_PROG : PW_IDLE;
      end else if (buf_wr) begin
        off_q <= off_q + 1'b1;  // wraps inside the page
      end else if (state_q == PW_PROG && tmr_done) begin
        state_q <= PW_IDLE;
      end
    end
  end

  pw_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_i      (buf_wr),
    .wr_idx_i  (off_q),
    .wr_data_i (byte_i),
    .rd_idx_i  (tmr_idx),
    .rd_data_o (buf_data),
    .rd_mark_o (buf_mark),
    .any_o     (buf_any)
  );

  pw_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmr_start),
    .busy_o    (tmr_busy),
    .done_o    (tmr_done),
    .idx_vld_o (tmr_idx_vld),
    .idx_o     (tmr_idx)
  );

  assign busy_o      = tmr_busy;
  assign ack_vld_o   = ack_vld_q;
  assign ack_o       = ack_q;
  assign mem_we_o    = tmr_idx_vld && buf_mark;
  assign mem_addr_o  = {page_q, tmr_idx};
  assign mem_wdata_o = buf_data;
endmodule

// File: rtl/pw_engine_chk.sv
module pw_engine_chk #(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 2000000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              busy_o,
  input logic              ack_vld_o,
  input logic              ack_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  int unsigned run_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      run_q  <= busy_o ? run_q + 1 : 0;
    end
  end

  p_we_in_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  p_one_page_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && mem_we_o && $past(mem_we_o)) |-> (mem_addr_o[ADDR_W-1:4] == $past(mem_addr_o[ADDR_W-1:4])));

  p_ack_qual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_vld_o);

  p_quiet_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !ack_vld_o);

  p_rise_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(busy_o)) |-> $past(stop_i));

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(busy_o)) |-> (run_q == PROG_CYCLES));
endmodule

bind pw_engine pw_engine_chk #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .ack_vld_o  (ack_vld_o),
  .ack_o      (ack_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/pw_engine_test.sv
`timescale 1ns/1ps
module pw_engine_test;
  localparam int PROG = 40;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_start = 1'b0, byte_vld = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic       busy, ack_vld, ack, mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2.5 clk = ~clk;

  pw_engine #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_start_i(wr_start), .addr_i(addr),
    .byte_vld_i(byte_vld), .byte_i(din), .stop_i(stop), .wp_i(wp),
    .busy_o(busy), .ack_vld_o(ack_vld), .ack_o(ack), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // array model
  logic [7:0] tb_mem [1024];
  logic [7:0] exp_mem [1024];
  always @(posedge clk) if (mem_we) tb_mem[mem_addr] <= mem_wdata;

  int vectors = 0, fails = 0;
  string phase = "R1";

  // reference model
  int  m_left = 0, m_page = 0, m_off = 0;
  bit  m_open = 0, e_vld = 0, e_ack = 0, prev_busy = 0;
  logic [7:0] pend [int];

  task automatic mem_cmp(string tag);
    int bad = 0;
    for (int i = 0; i < 1024; i++) begin
      if (tb_mem[i] !== exp_mem[i]) begin
        if (bad == 0)
          $display("FAIL %s array[%0h] actual %0h expected %0h", tag, i, tb_mem[i], exp_mem[i]);
        bad++;
      end
    end
    vectors++;
    if (bad != 0) fails++;
  endtask

  always @(posedge clk) begin
    if (rst_ni) begin
      e_vld = 0; e_ack = 0;
      if (m_left > 0) m_left--;
      else if (wr_start) begin
        m_open = 1; m_page = int'(addr) >> 4; m_off = int'(addr) % 16; pend.delete();
      end else if (stop) begin
        if (m_open && pend.num() > 0) begin
          m_left = PROG;
          foreach (pend[k]) exp_mem[m_page*16 + k] = pend[k];
        end
        m_open = 0;
      end else if (byte_vld && m_open) begin
        e_vld = 1;
        if (wp && m_page >= 32) e_ack = 0;
        else begin
          e_ack = 1; pend[m_off] = din; m_off = (m_off + 1) % 16;
        end
      end
      #1;
      vectors++;
      if (busy !== (m_left > 0)) begin
        fails++; $display("FAIL R7 (%s) busy actual %0b expected %0b", phase, busy, m_left > 0);
      end
      vectors++;
      if (ack_vld !== e_vld || ack !== e_ack) begin
        fails++; $display("FAIL R4 (%s) ack actual %0b/%0b expected %0b/%0b", phase, ack_vld, ack, e_vld, e_ack);
      end
      if (mem_we === 1'b1 && m_left == 0) begin
        fails++; $display("FAIL R11 (%s) write outside interval actual 1 expected 0", phase);
      end
      if (prev_busy && m_left == 0) mem_cmp(phase);
      prev_busy = (m_left > 0);
    end
  end

  task automatic tick(); @(negedge clk); wr_start = 0; byte_vld = 0; stop = 0; endtask
  task automatic do_start(input logic [9:0] a);
    @(negedge clk); addr = a; wr_start = 1; byte_vld = 0; stop = 0;
  endtask
  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); din = d; byte_vld = 1; wr_start = 0; stop = 0;
  endtask
  task automatic do_stop(); @(negedge clk); stop = 1; wr_start = 0; byte_vld = 0; endtask
  task automatic settle(); tick(); while (busy) tick(); tick(); tick(); endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R7 watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      tb_mem[i] = 8'(i) ^ 8'h5A; exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    #12;
    vectors++;
    if (busy !== 0 || ack_vld !== 0 || ack !== 0 || mem_we !== 0) begin
      fails++; $display("FAIL R1 reset outputs actual %0b%0b%0b%0b expected 0000", busy, ack_vld, ack, mem_we);
    end
    @(negedge clk); rst_ni = 1;

    phase = "R12"; do_byte(8'h11); do_stop(); settle();

    phase = "R2"; do_start(10'h013);
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3); do_stop(); settle();
    phase = "R8"; mem_cmp("R8");

    phase = "R3"; do_start(10'h0AE);
    for (int i = 0; i < 20; i++) do_byte(8'(8'hC0 + i));
    do_stop(); settle();

    phase = "R5"; wp = 1; do_start(10'h2F0);
    do_byte(8'hEE); do_byte(8'hEF); do_stop(); settle();
    mem_cmp("R5");
    do_start(10'h1F8); do_byte(8'h77); do_stop(); settle();

    phase = "R6"; wp = 0; do_start(10'h3FF);
    do_byte(8'h31); do_byte(8'h32); do_stop(); settle();

    phase = "R9"; do_start(10'h100); do_byte(8'h55); do_stop();
    do_start(10'h200); do_byte(8'h66); do_byte(8'h67); do_stop();
    settle();
    do_stop(); do_byte(8'h99); settle();
    mem_cmp("R9");

    phase = "R10"; do_start(10'h150); do_stop(); settle();
    do_start(10'h151); do_byte(8'h44); do_start(10'h160); do_stop(); settle();
    mem_cmp("R10");

    phase = "R2"; do_start(10'h161); do_byte(8'h12); do_start(10'h165); do_byte(8'h34); do_stop(); settle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule